// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Unit

This block watches two 8-bit input ports and raises an interrupt when an enabled pin trips its change condition. Each pin has an enable bit, a compare-mode bit and a default value. In the first compare mode a pin trips when it differs from its value one clock earlier. In the second mode it trips when it differs from its stored default. When a port has no interrupt pending and one or more of its enabled pins trip, the block latches those pins as flags. In the same cycle it captures the whole port value.

A pending port holds its flags and its capture until the register file reports a read of that port's capture register or of its pin-value register. Two interrupt outputs, one per port, are produced from the pending state. Three configuration bits shape them: mirroring, which ORs both ports onto both outputs; polarity; and open-drain drive. Each output is given as a drive value and an output enable. Pin synchronization and the register bus sit outside the block.

Top module: `gpio_ioc_unit`

## Requirements
- R1: A pin whose enable bit is 0 never sets a flag, whatever its value or mode.
- R2: With the compare-mode bit 0, an enabled pin trips when its sampled value differs from its value one clock earlier. Flag bit i set to 1 marks pin i as a cause of the pending interrupt.
- R3: With the compare-mode bit 1, an enabled pin trips when its value differs from the matching default-value bit.
- R4: On the clock edge where a port with no pending flags has at least one tripping pin, the flags take the tripping-pin mask and the capture register takes the port's pin values. Both are visible after that edge.
- R5: While any flag of a port is set, further trips on that port change neither its flags nor its capture register.
- R6: A capture-read or port-read strobe for a port clears that port's flags on the next edge. It leaves the other port untouched, and no new event is latched on that edge.
- R7: After a clear, a pin in compare-to-default mode whose mismatch persists does not trip again until it has matched its default for at least one cycle.
- R8: With the mirror bit (config bit 6) set, both interrupt outputs show the OR of the two ports' pending states. With it clear, each output shows only its own port.
- R9: With open-drain off, the output enable is 1. The drive value is the pending state when the polarity bit (config bit 1) is 1, and its inverse when that bit is 0.
- R10: With the open-drain bit (config bit 2) set, the drive value is always 0 and the output enable equals the pending state, whatever the polarity bit is.
- R11: After reset the flags and captures are 0. No compare-to-previous trip occurs on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinA | input | 8 | Synchronized pin values, port A |
| pinB | input | 8 | Synchronized pin values, port B |
| enA | input | 8 | Per-pin interrupt enable, port A |
| enB | input | 8 | Per-pin interrupt enable, port B |
| ctlA | input | 8 | Per-pin compare mode, port A (1 = against default) |
| ctlB | input | 8 | Per-pin compare mode, port B (1 = against default) |
| defA | input | 8 | Default compare values, port A |
| defB | input | 8 | Default compare values, port B |
| cfgMirror | input | 1 | Config bit 6: OR both ports onto both outputs |
| cfgOpenDrain | input | 1 | Config bit 2: open-drain interrupt outputs |
| cfgPolarity | input | 1 | Config bit 1: 1 = active-high, 0 = active-low |
| rdCapA | input | 1 | Read strobe of the port A capture register |
| rdCapB | input | 1 | Read strobe of the port B capture register |
| rdPortA | input | 1 | Read strobe of the port A pin-value register |
| rdPortB | input | 1 | Read strobe of the port B pin-value register |
| flagA | output | 8 | Interrupt flags, port A |
| flagB | output | 8 | Interrupt flags, port B |
| capA | output | 8 | Captured pin values, port A |
| capB | output | 8 | Captured pin values, port B |
| intAOut | output | 1 | Interrupt A drive value |
| intAOe | output | 1 | Interrupt A output enable |
| intBOut | output | 1 | Interrupt B drive value |
| intBOe | output | 1 | Interrupt B output enable |

## Verification
The bench targets the first edge after reset. A design that compares against an unprimed previous value would raise a false interrupt there. It holds a default mismatch across a clear. A design that does not re-arm would either fire again at once or never fire again. It changes pins while an interrupt is pending, which catches a capture that keeps updating. It also crosses the three configuration bits with a pending state on only one port, so a swapped polarity, a mirror that does not OR, or open-drain that still drives high shows up on the idle output.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int NPORT = 2;

  typedef struct packed {
    logic [NPORT-1:0] load;
    logic [NPORT-1:0] clear;
  } iocStrobe_t;
endpackage

// File: rtl/ioc_datapath.sv
module ioc_datapath
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NPORT-1:0][W-1:0]    pins,
  input  logic [NPORT-1:0][W-1:0]    defVal,
  input  logic [NPORT-1:0][W-1:0]    trip,
  input  iocStrobe_t                 stb,
  output logic [NPORT-1:0][W-1:0]    chgDiff,
  output logic [NPORT-1:0][W-1:0]    defDiff,
  output logic [NPORT-1:0][W-1:0]    flags,
  output logic [NPORT-1:0][W-1:0]    caps
);
  logic                    primedQ;
  logic [NPORT-1:0][W-1:0] prevQ;
  logic [NPORT-1:0][W-1:0] flagQ;
  logic [NPORT-1:0][W-1:0] capQ;

  always_ff @(posedge clk) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ[p] <= '0;
        flagQ[p] <= '0;
        capQ[p]  <= '0;
      end else begin
        prevQ[p] <= pins[p];
        if (stb.clear[p]) begin
          flagQ[p] <= '0;
        end else if (stb.load[p]) begin
          flagQ[p] <= trip[p];
          capQ[p]  <= pins[p];
        end
      end
    end

    assign chgDiff[p] = primedQ ? (pins[p] ^ prevQ[p]) : '0;
    assign defDiff[p] = pins[p] ^ defVal[p];
    assign flags[p]   = flagQ[p];
    assign caps[p]    = capQ[p];
  end
endmodule

// File: rtl/ioc_control.sv
module ioc_control
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NPORT-1:0][W-1:0] en,
  input  logic [NPORT-1:0][W-1:0] ctl,
  input  logic [NPORT-1:0][W-1:0] chgDiff,
  input  logic [NPORT-1:0][W-1:0] defDiff,
  input  logic [NPORT-1:0][W-1:0] flags,
  input  logic [NPORT-1:0]        rdClr,
  input  logic                    cfgMirror,
  input  logic                    cfgOpenDrain,
  input  logic                    cfgPolarity,
  output iocStrobe_t              stb,
  output logic [NPORT-1:0][W-1:0] trip,
  output logic [NPORT-1:0]        intOut,
  output logic [NPORT-1:0]        intOe
);
  logic [NPORT-1:0][W-1:0] blockQ;
  logic [NPORT-1:0]        pending;
  logic                    anyPending;
  logic [NPORT-1:0]        active;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [W-1:0] defMiss;
    assign defMiss    = ctl[p] & defDiff[p];
    assign trip[p]    = en[p] & ((defMiss & ~blockQ[p]) | (~ctl[p] & chgDiff[p]));
    assign pending[p] = |flags[p];

    always_comb begin
      stb.clear[p] = rdClr[p];
      stb.load[p]  = !pending[p] && (|trip[p]) && !rdClr[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          blockQ[p] <= '0;
      else if (rdClr[p])  blockQ[p] <= defMiss;
      else                blockQ[p] <= blockQ[p] & defMiss;
    end

    assign active[p] = cfgMirror ? anyPending : pending[p];
    assign intOe[p]  = cfgOpenDrain ? active[p] : 1'b1;
    assign intOut[p] = cfgOpenDrain ? 1'b0 : (cfgPolarity ? active[p] : !active[p]);
  end

  assign anyPending = |pending;
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinA,
  input  logic [W-1:0] pinB,
  input  logic [W-1:0] enA,
  input  logic [W-1:0] enB,
  input  logic [W-1:0] ctlA,
  input  logic [W-1:0] ctlB,
  input  logic [W-1:0] defA,
  input  logic [W-1:0] defB,
  input  logic         cfgMirror,
  input  logic         cfgOpenDrain,
  input  logic         cfgPolarity,
  input  logic         rdCapA,
  input  logic         rdCapB,
  input  logic         rdPortA,
  input  logic         rdPortB,
  output logic [W-1:0] flagA,
  output logic [W-1:0] flagB,
  output logic [W-1:0] capA,
  output logic [W-1:0] capB,
  output logic         intAOut,
  output logic         intAOe,
  output logic         intBOut,
  output logic         intBOe
);
  iocStrobe_t              stb;
  logic [NPORT-1:0][W-1:0] pins, enV, ctlV, defV, trip, chgDiff, defDiff, flags, caps;
  logic [NPORT-1:0]        rdClr, intOut, intOe;

  assign pins  = {pinB, pinA};
  assign enV   = {enB, enA};
  assign ctlV  = {ctlB, ctlA};
  assign defV  = {defB, defA};
  assign rdClr = {rdCapB | rdPortB, rdCapA | rdPortA};

  ioc_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .pins(pins), .defVal(defV), .trip(trip), .stb(stb),
    .chgDiff(chgDiff), .defDiff(defDiff), .flags(flags), .caps(caps)
  );

  ioc_control #(.W(W)) u_ctl (
    .clk(clk), .rstN(rstN), .en(enV), .ctl(ctlV), .chgDiff(chgDiff), .defDiff(defDiff),
    .flags(flags), .rdClr(rdClr), .cfgMirror(cfgMirror), .cfgOpenDrain(cfgOpenDrain),
    .cfgPolarity(cfgPolarity), .stb(stb), .trip(trip), .intOut(intOut), .intOe(intOe)
  );

  assign flagA   = flags[0];
  assign flagB   = flags[1];
  assign capA    = caps[0];
  assign capB    = caps[1];
  assign intAOut = intOut[0];
  assign intAOe  = intOe[0];
  assign intBOut = intOut[1];
  assign intBOe  = intOe[1];
endmodule

// File: rtl/ioc_checker.sv
module ioc_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] enA,
  input logic [W-1:0] enB,
  input logic         rdCapA,
  input logic         rdPortA,
  input logic         rdCapB,
  input logic         rdPortB,
  input logic         cfgMirror,
  input logic         cfgOpenDrain,
  input logic [W-1:0] flagA,
  input logic [W-1:0] flagB,
  input logic [W-1:0] capA,
  input logic [W-1:0] capB,
  input logic         intAOut,
  input logic         intAOe,
  input logic         intBOut,
  input logic         intBOe
);
  assert_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flagA == '0 && enA == '0) |=> (flagA == '0));

  assert_mask_b_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flagB == '0 && enB == '0) |=> (flagB == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagA != '0 && !rdCapA && !rdPortA) |=> ($stable(capA) && $stable(flagA)));

  assert_hold_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagB != '0 && !rdCapB && !rdPortB) |=> ($stable(capB) && $stable(flagB)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdCapA || rdPortA) |=> (flagA == '0));

  assert_clear_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdCapB || rdPortB) |=> (flagB == '0));

  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgMirror |-> (intAOut == intBOut && intAOe == intBOe));

  assert_pushpull_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpenDrain |-> (intAOe && intBOe));

  assert_opendrain_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgOpenDrain |-> (!intAOut && !intBOut));
endmodule

bind gpio_ioc_unit ioc_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .enA(enA), .enB(enB), .rdCapA(rdCapA), .rdPortA(rdPortA),
  .rdCapB(rdCapB), .rdPortB(rdPortB), .cfgMirror(cfgMirror), .cfgOpenDrain(cfgOpenDrain),
  .flagA(flagA), .flagB(flagB), .capA(capA), .capB(capB),
  .intAOut(intAOut), .intAOe(intAOe), .intBOut(intBOut), .intBOe(intBOe)
);

// File: tb/test_gpio_ioc_unit.sv
module test_gpio_ioc_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinA = '0, pinB = '0, enA = '0, enB = '0, ctlA = '0, ctlB = '0;
  logic [7:0] defA = '0, defB = '0;
  logic cfgMirror = 0, cfgOpenDrain = 0, cfgPolarity = 0;
  logic rdCapA = 0, rdCapB = 0, rdPortA = 0, rdPortB = 0;
  logic [7:0] flagA, flagB, capA, capB;
  logic intAOut, intAOe, intBOut, intBOe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] mFlag [2];
  logic [7:0] mCap [2];
  logic [7:0] mPrev [2];
  logic [7:0] mBlk [2];
  bit mPrimed;

  gpio_ioc_unit i_gpio_ioc_unit (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .enA(enA), .enB(enB),
    .ctlA(ctlA), .ctlB(ctlB), .defA(defA), .defB(defB), .cfgMirror(cfgMirror),
    .cfgOpenDrain(cfgOpenDrain), .cfgPolarity(cfgPolarity), .rdCapA(rdCapA),
    .rdCapB(rdCapB), .rdPortA(rdPortA), .rdPortB(rdPortB), .flagA(flagA), .flagB(flagB),
    .capA(capA), .capB(capB), .intAOut(intAOut), .intAOe(intAOe), .intBOut(intBOut),
    .intBOe(intBOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        mFlag[p] = '0; mCap[p] = '0; mPrev[p] = '0; mBlk[p] = '0;
      end
      mPrimed = 0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] pv, en, ct, dv, hit;
        bit clr;
        pv = p ? pinB : pinA;  en = p ? enB : enA;
        ct = p ? ctlB : ctlA;  dv = p ? defB : defA;
        clr = p ? (rdCapB || rdPortB) : (rdCapA || rdPortA);
        hit = '0;
        for (int i = 0; i < 8; i++) begin
          if (en[i]) begin
            if (ct[i]) hit[i] = (pv[i] != dv[i]) && !mBlk[p][i];
            else       hit[i] = mPrimed && (pv[i] != mPrev[p][i]);
          end
        end
        if (clr) mFlag[p] = '0;
        else if (mFlag[p] == '0 && hit != '0) begin
          mFlag[p] = hit;
          mCap[p]  = pv;
        end
        for (int i = 0; i < 8; i++) begin
          if (ct[i] && pv[i] != dv[i]) mBlk[p][i] = clr ? 1'b1 : mBlk[p][i];
          else                         mBlk[p][i] = 1'b0;
        end
        mPrev[p] = pv;
      end
      mPrimed = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    bit actA, actB, aA, aB;
    actA = (mFlag[0] != 0);
    actB = (mFlag[1] != 0);
    aA = cfgMirror ? (actA || actB) : actA;
    aB = cfgMirror ? (actA || actB) : actB;
    chk("R4 model flagA", flagA, mFlag[0]);
    chk("R4 model flagB", flagB, mFlag[1]);
    chk("R4 model capA", capA, mCap[0]);
    chk("R4 model capB", capB, mCap[1]);
    chk("R8 model intAOe", intAOe, cfgOpenDrain ? aA : 1'b1);
    chk("R8 model intBOe", intBOe, cfgOpenDrain ? aB : 1'b1);
    chk("R9 model intAOut", intAOut, cfgOpenDrain ? 1'b0 : (cfgPolarity ? aA : !aA));
    chk("R9 model intBOut", intBOut, cfgOpenDrain ? 1'b0 : (cfgPolarity ? aB : !aB));
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rstN) compareModel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pinA = 8'hFF; enA = 8'hFF;
    tick(); tick();
    chk("R11 reset flagA", flagA, 8'h00);
    chk("R11 reset capA", capA, 8'h00);
    chk("R11 reset intAOut idle high", intAOut, 1'b1);
    rstN = 1'b1;
    tick(); tick();
    chk("R11 no trip after reset", flagA, 8'h00);

    enA = 8'h0F; pinA = 8'h0F; tick();
    chk("R1 masked pins ignored", flagA, 8'h00);

    pinA = 8'h0E; tick();
    chk("R2 change trips flag", flagA, 8'h01);
    chk("R4 capture value", capA, 8'h0E);
    chk("R9 active-low asserted", intAOut, 1'b0);

    pinA = 8'h0C; tick();
    chk("R5 flags held", flagA, 8'h01);
    chk("R5 capture held", capA, 8'h0E);

    rdCapA = 1; tick(); rdCapA = 0;
    chk("R6 capture read clears", flagA, 8'h00);
    tick();
    chk("R6 stays clear", flagA, 8'h00);

    enB = 8'hFF; pinB = 8'h01; tick();
    chk("R2 port B flag", flagB, 8'h01);
    chk("R4 port B capture", capB, 8'h01);
    rdPortA = 1; tick(); rdPortA = 0;
    chk("R6 other port kept", flagB, 8'h01);

    cfgMirror = 1; #1;
    chk("R8 mirror drives idle A", intAOut, 1'b0);
    cfgMirror = 0; #1;
    chk("R8 no mirror A idle", intAOut, 1'b1);
    cfgPolarity = 1; #1;
    chk("R9 active-high B", intBOut, 1'b1);
    chk("R9 active-high A idle", intAOut, 1'b0);
    cfgOpenDrain = 1; #1;
    chk("R10 open-drain B low", intBOut, 1'b0);
    chk("R10 open-drain B enabled", intBOe, 1'b1);
    chk("R10 open-drain A released", intAOe, 1'b0);
    cfgOpenDrain = 0; cfgPolarity = 0;
    rdPortB = 1; tick(); rdPortB = 0;
    chk("R6 port read clears B", flagB, 8'h00);

    enA = 8'h80; ctlA = 8'h80; defA = 8'h00; pinA = 8'h8C; tick();
    chk("R3 default mismatch trips", flagA, 8'h80);
    chk("R3 capture", capA, 8'h8C);
    rdCapA = 1; tick(); rdCapA = 0;
    chk("R6 clear default trip", flagA, 8'h00);
    tick();
    chk("R7 persistent mismatch blocked", flagA, 8'h00);
    pinA = 8'h0C; tick();
    chk("R7 match no trip", flagA, 8'h00);
    pinA = 8'h8C; tick();
    chk("R7 re-armed", flagA, 8'h80);
    rdCapA = 1; tick(); rdCapA = 0;

    for (int n = 0; n < 3000; n++) begin
      if ((n % 40) == 0) begin
        enA = 8'($urandom); enB = 8'($urandom); ctlA = 8'($urandom); ctlB = 8'($urandom);
        defA = 8'($urandom); defB = 8'($urandom);
        cfgMirror = 1'($urandom); cfgOpenDrain = 1'($urandom); cfgPolarity = 1'($urandom);
      end
      if (($urandom % 4) == 0) pinA = pinA ^ (8'h1 << ($urandom % 8));
      if (($urandom % 4) == 0) pinB = pinB ^ (8'h1 << ($urandom % 8));
      rdCapA  = (($urandom % 9) == 0);
      rdPortA = (($urandom % 13) == 0);
      rdCapB  = (($urandom % 9) == 0);
      rdPortB = (($urandom % 13) == 0);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule